// File: doc/BRIEF.md
# Execution Mode Summary Register

This block keeps a registered one-word summary of the processor's execution mode. It holds shadow copies of the few control bits that decide the mode: the long-mode-active bit of the extended-feature register, the protection-enable and paging bits of CR0, the virtual-8086 flag, the code-segment privilege, default-size and long attributes, and the stack-segment default-size attribute. From these bits it derives the mode, the submode, the privilege level, the paging and protection bits, the default and alternate operand and address sizes, and the stack size.

Software-side logic writes the source registers through a single write port that has a selector. An ordinary write stores the relevant bits and recomputes the summary at the same clock edge, using the new value together with the other stored sources. A quiet write stores the bits but leaves the summary alone. A write to the summary's own selector is a refresh strobe. It discards its data and recomputes the summary from whatever is currently stored, which brings the summary back in line after quiet writes.

Top module: `exec_mode_decoder`

## Requirements
- R1: `mode_word_o` packs these fields, listed from the LSB: mode [0] (0 legacy, 1 long); submode [3:1] (0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit); privilege [5:4]; paging [6]; protection [7]; default operand size [9:8]; alternate operand size [11:10]; default address size [13:12]; alternate address size [15:14]; stack size [17:16]. Each size field encodes 1 = 16-bit, 2 = 32-bit, 3 = 64-bit.
- R2: While reset is asserted, and after it is released, the word is legacy/real with privilege, paging and protection all 0. Operand and address sizes are default 16-bit and alternate 32-bit, and the stack is 16-bit (word 18'h19900).
- R3: When the stored long-active bit (bit 10 of an extended-feature write, selector 0) is 1, the mode is long. The submode is 64-bit if the stored code-segment long bit (bit 3 of a code-segment write, selector 2) is 1, and compatibility otherwise.
- R4: When long-active is 0, the mode is legacy and the code-segment long bit has no effect on the submode. The submode is real when protection enable (CR0 bit 0, selector 1) is 0. It is virtual-8086 when protection enable is 1 and the VM flag (bit 17 of a flags write, selector 4) is 1, and protected when protection enable is 1 and VM is 0.
- R5: Privilege equals code-segment bits [1:0]. Paging equals CR0 bit 31 and protection equals CR0 bit 0.
- R6: The operand sizes are default 32-bit and alternate 16-bit in the 64-bit submode, or when the code-segment default-size bit (bit 2) is 1. Otherwise they are default 16-bit and alternate 32-bit.
- R7: The address sizes are default 64-bit and alternate 32-bit in the 64-bit submode. Outside that submode they are default 32-bit and alternate 16-bit when the code-segment default-size bit is 1, and default 16-bit and alternate 32-bit otherwise.
- R8: The stack size is 64-bit in the 64-bit submode. Otherwise it is 32-bit when the stack-segment default-size bit (bit 2 of a selector 3 write) is 1, and 16-bit when that bit is 0.
- R9: A write with `wr_quiet_i` low to selectors 0 to 4 updates the word at the clock edge that accepts it. The new word uses the written value together with the other stored sources. Without a write, the word does not change.
- R10: A write with `wr_quiet_i` high to selectors 0 to 4 stores the source bits but leaves the word unchanged.
- R11: A write with `wr_quiet_i` low to selector 5 recomputes the word from the stored sources and discards its data. A quiet write to selector 5, or any write to selector 6 or 7, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_quiet_i | input | 1 | Store without recomputing the summary |
| wr_sel_i | input | 3 | Target: 0 ext-feature, 1 CR0, 2 code seg, 3 stack seg, 4 flags, 5 summary |
| wr_data_i | input | DATA_W | Write data |
| mode_word_o | output | 18 | Packed mode summary |

## Verification
The bench walks every legacy submode and both long submodes. It sets the code-segment long bit while long-active is clear; a decoder that ignored long-active there would report 64-bit and 64-bit stack sizes. Quiet writes are followed by idle cycles and then by a refresh. A design that recomputed on quiet writes would change the word too early, and one that did not store quiet data would refresh to a stale mode. The refresh carries all-ones data, so a design that stored that data would show a corrupted word. Writes to the unused selectors and quiet refreshes must leave the word untouched. A 32-step sweep then crosses the default-size bits with both long submodes to catch mixed-up size priorities.

// File: rtl/exec_mode_pkg.sv
package exec_mode_pkg;
  typedef enum logic {MODE_LEGACY = 1'b0, MODE_LONG = 1'b1} mode_e;
  typedef enum logic [2:0] {
    SUB_REAL = 3'd0, SUB_PROT = 3'd1, SUB_V86 = 3'd2, SUB_COMPAT = 3'd3, SUB_BIT64 = 3'd4
  } submode_e;
  typedef enum logic [1:0] {SZ_NONE = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2, SZ_64 = 2'd3} size_e;

  localparam logic [2:0] SEL_EXT     = 3'd0;
  localparam logic [2:0] SEL_CR0     = 3'd1;
  localparam logic [2:0] SEL_CS      = 3'd2;
  localparam logic [2:0] SEL_SS      = 3'd3;
  localparam logic [2:0] SEL_FLAGS   = 3'd4;
  localparam logic [2:0] SEL_SUMMARY = 3'd5;

  typedef struct packed {
    logic       lma;
    logic       pe;
    logic       pg;
    logic       vm;
    logic [1:0] cs_dpl;
    logic       cs_def;
    logic       cs_long;
    logic       ss_def;
  } src_t;

  typedef struct packed {
    size_e      stack;
    size_e      alt_addr;
    size_e      def_addr;
    size_e      alt_op;
    size_e      def_op;
    logic       prot;
    logic       paging;
    logic [1:0] cpl;
    submode_e   submode;
    mode_e      mode;
  } summary_t;

  localparam int SUMMARY_W = $bits(summary_t);
endpackage

// File: rtl/exec_mode_src_regs.sv
module exec_mode_src_regs
  import exec_mode_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int LMA_BIT     = 10,
  parameter int PE_BIT      = 0,
  parameter int PG_BIT      = 31,
  parameter int VM_BIT      = 17,
  parameter int DPL_LSB     = 0,
  parameter int CS_DEF_BIT  = 2,
  parameter int CS_LONG_BIT = 3,
  parameter int SS_DEF_BIT  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_quiet_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output src_t              nxt_o,
  output logic              recompute_o
);
  src_t cur_q;
  logic unused_data;

  assign unused_data = ^wr_data_i;

  always_comb begin
    nxt_o = cur_q;
    if (wr_en_i) begin
      case (wr_sel_i)
        SEL_EXT:   nxt_o.lma = wr_data_i[LMA_BIT];
        SEL_CR0: begin
          nxt_o.pe = wr_data_i[PE_BIT];
          nxt_o.pg = wr_data_i[PG_BIT];
        end
        SEL_CS: begin
          nxt_o.cs_dpl  = wr_data_i[DPL_LSB +: 2];
          nxt_o.cs_def  = wr_data_i[CS_DEF_BIT];
          nxt_o.cs_long = wr_data_i[CS_LONG_BIT];
        end
        SEL_SS:    nxt_o.ss_def = wr_data_i[SS_DEF_BIT];
        SEL_FLAGS: nxt_o.vm = wr_data_i[VM_BIT];
        default: ;
      endcase
    end
  end

  // Quiet writes store; only loud writes to a defined selector recompute.
  assign recompute_o = wr_en_i && !wr_quiet_i && (wr_sel_i <= SEL_SUMMARY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else         cur_q <= nxt_o;
  end

  // R11: unused selectors never recompute
  p_bad_sel_no_update_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i > SEL_SUMMARY) |-> !recompute_o);
endmodule

// File: rtl/exec_mode_decode.sv
module exec_mode_decode
  import exec_mode_pkg::*;
(
  input  src_t     src_i,
  output summary_t sum_o
);
  logic is64;

  assign is64 = src_i.lma && src_i.cs_long;

  always_comb begin
    if (src_i.lma) begin
      sum_o.mode    = MODE_LONG;
      sum_o.submode = src_i.cs_long ? SUB_BIT64 : SUB_COMPAT;
    end else begin
      sum_o.mode = MODE_LEGACY;
      if (!src_i.pe)     sum_o.submode = SUB_REAL;
      else if (src_i.vm) sum_o.submode = SUB_V86;
      else               sum_o.submode = SUB_PROT;
    end
    sum_o.cpl    = src_i.cs_dpl;
    sum_o.paging = src_i.pg;
    sum_o.prot   = src_i.pe;

    if (is64 || src_i.cs_def) begin
      sum_o.def_op = SZ_32;
      sum_o.alt_op = SZ_16;
    end else begin
      sum_o.def_op = SZ_16;
      sum_o.alt_op = SZ_32;
    end

    if (is64) begin
      sum_o.def_addr = SZ_64;
      sum_o.alt_addr = SZ_32;
    end else if (src_i.cs_def) begin
      sum_o.def_addr = SZ_32;
      sum_o.alt_addr = SZ_16;
    end else begin
      sum_o.def_addr = SZ_16;
      sum_o.alt_addr = SZ_32;
    end

    if (is64)              sum_o.stack = SZ_64;
    else if (src_i.ss_def) sum_o.stack = SZ_32;
    else                   sum_o.stack = SZ_16;
  end
endmodule

// File: rtl/exec_mode_summary_reg.sv
module exec_mode_summary_reg
  import exec_mode_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     upd_i,
  input  summary_t nxt_i,
  output summary_t q_o
);
  localparam summary_t RESET_VAL = '{
    stack: SZ_16, alt_addr: SZ_32, def_addr: SZ_16, alt_op: SZ_32, def_op: SZ_16,
    prot: 1'b0, paging: 1'b0, cpl: 2'd0, submode: SUB_REAL, mode: MODE_LEGACY
  };

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= RESET_VAL;
    else if (upd_i) q_o <= nxt_i;
  end

  // R9: no recompute, no change
  p_hold_without_update_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(q_o));
endmodule

// File: rtl/exec_mode_decoder.sv
module exec_mode_decoder
  import exec_mode_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int LMA_BIT     = 10,
  parameter int PE_BIT      = 0,
  parameter int PG_BIT      = 31,
  parameter int VM_BIT      = 17,
  parameter int DPL_LSB     = 0,
  parameter int CS_DEF_BIT  = 2,
  parameter int CS_LONG_BIT = 3,
  parameter int SS_DEF_BIT  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 wr_quiet_i,
  input  logic [2:0]           wr_sel_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [SUMMARY_W-1:0] mode_word_o
);
  src_t     src_nxt;
  logic     recompute;
  summary_t sum_nxt;
  summary_t sum_q;

  exec_mode_src_regs #(
    .DATA_W(DATA_W), .LMA_BIT(LMA_BIT), .PE_BIT(PE_BIT), .PG_BIT(PG_BIT),
    .VM_BIT(VM_BIT), .DPL_LSB(DPL_LSB), .CS_DEF_BIT(CS_DEF_BIT),
    .CS_LONG_BIT(CS_LONG_BIT), .SS_DEF_BIT(SS_DEF_BIT)
  ) u_src (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_quiet_i(wr_quiet_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .nxt_o(src_nxt), .recompute_o(recompute)
  );

  exec_mode_decode u_dec (.src_i(src_nxt), .sum_o(sum_nxt));

  exec_mode_summary_reg u_sum (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(recompute), .nxt_i(sum_nxt), .q_o(sum_q)
  );

  assign mode_word_o = sum_q;

  // R5: CR0 write lands in paging/protection
  p_cr0_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_quiet_i && wr_sel_i == SEL_CR0) |=>
      (sum_q.paging == $past(wr_data_i[PG_BIT]) && sum_q.prot == $past(wr_data_i[PE_BIT])));
  // R10: quiet writes leave the word alone
  p_quiet_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_quiet_i) |=> $stable(mode_word_o));
  // R3: long mode only reports long submodes
  p_long_submode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_q.mode == MODE_LONG) |-> (sum_q.submode == SUB_COMPAT || sum_q.submode == SUB_BIT64));
  // R4: legacy mode only reports legacy submodes
  p_legacy_submode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_q.mode == MODE_LEGACY) |-> (sum_q.submode <= SUB_V86));
  // R7: 64-bit submode widths
  p_bit64_sizes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_q.submode == SUB_BIT64) |->
      (sum_q.def_addr == SZ_64 && sum_q.alt_addr == SZ_32 && sum_q.stack == SZ_64));
  // R6: operand sizes are always a 16/32 pair
  p_op_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_q.def_op != SZ_NONE && sum_q.def_op != SZ_64 && sum_q.alt_op != sum_q.def_op &&
     sum_q.alt_op != SZ_NONE && sum_q.alt_op != SZ_64));
endmodule

// File: tb/exec_mode_decoder_tb.sv
`timescale 1ns/1ps
module exec_mode_decoder_tb;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_quiet = 1'b0;
  logic [2:0]    wr_sel = 3'd0;
  logic [DW-1:0] wr_data = '0;
  logic [17:0]   word;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [17:0] exp_q[$];
  string       tag_q[$];

  // bench model of stored sources
  logic m_lma = 0, m_pe = 0, m_pg = 0, m_vm = 0, m_def = 0, m_long = 0, m_ss = 0;
  logic [1:0] m_dpl = 0;
  logic [17:0] m_word = 18'h19900;

  always #10 clk = ~clk;

  exec_mode_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_quiet_i(wr_quiet),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .mode_word_o(word)
  );

  function automatic logic [17:0] model_word();
    logic [2:0] sub;
    logic [1:0] dop, aop, dad, aad, stk;
    logic b64;
    b64 = m_lma && m_long;
    if (m_lma) sub = m_long ? 3'd4 : 3'd3;
    else if (!m_pe) sub = 3'd0;
    else sub = m_vm ? 3'd2 : 3'd1;
    if (b64 || m_def) begin dop = 2; aop = 1; end else begin dop = 1; aop = 2; end
    if (b64) begin dad = 3; aad = 2; end
    else if (m_def) begin dad = 2; aad = 1; end
    else begin dad = 1; aad = 2; end
    stk = b64 ? 2'd3 : (m_ss ? 2'd2 : 2'd1);
    return {stk, aad, dad, aop, dop, m_pe, m_pg, m_dpl, sub, m_lma};
  endfunction

  task automatic drive(input logic en, input logic quiet, input logic [2:0] sel,
                       input logic [DW-1:0] data, input string tag);
    @(negedge clk);
    wr_en = en; wr_quiet = quiet; wr_sel = sel; wr_data = data;
    if (en && sel <= 3'd4) begin
      case (sel)
        3'd0: m_lma = data[10];
        3'd1: begin m_pe = data[0]; m_pg = data[31]; end
        3'd2: begin m_dpl = data[1:0]; m_def = data[2]; m_long = data[3]; end
        3'd3: m_ss = data[2];
        default: m_vm = data[17];
      endcase
    end
    if (en && !quiet && sel <= 3'd5) m_word = model_word();
    exp_q.push_back(m_word);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 1'b0, 3'd0, '0, tag);
  endtask

  // monitor: compare one item per cycle, 5 ns after the capturing edge
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [17:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (word !== e) begin
        fails++;
        $display("FAIL %s: word=%h expected=%h", t, word, e);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (word !== 18'h19900) begin
      fails++;
      $display("FAIL R2 in reset: word=%h expected=%h", word, 18'h19900);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (word !== 18'h19900) begin
      fails++;
      $display("FAIL R1 R2 after reset: word=%h expected=%h", word, 18'h19900);
    end

    drive(1, 0, 3'd1, 32'h0000_0001, "R4 R9 protected");
    drive(1, 0, 3'd4, 32'h0002_0000, "R4 virtual-8086");
    drive(1, 0, 3'd1, 32'h8000_0001, "R5 paging");
    drive(1, 0, 3'd4, 32'h0000_0000, "R4 back to protected");
    drive(1, 0, 3'd2, 32'h0000_0007, "R5 R6 R7 cpl and default size");
    drive(1, 0, 3'd3, 32'h0000_0004, "R8 stack 32");
    drive(1, 0, 3'd2, 32'h0000_000B, "R4 long attr ignored in legacy");
    drive(1, 0, 3'd0, 32'h0000_0400, "R3 R6 R7 R8 64-bit");
    drive(1, 0, 3'd2, 32'h0000_0000, "R3 R6 R7 compatibility");
    drive(1, 1, 3'd0, 32'h0000_0000, "R10 quiet ext write");
    drive(1, 1, 3'd1, 32'h0000_0000, "R10 quiet cr0 write");
    idle("R9 idle hold");
    idle("R9 idle hold");
    drive(1, 0, 3'd5, 32'hFFFF_FFFF, "R11 refresh discards data");
    drive(1, 1, 3'd2, 32'h0000_0008, "R10 quiet cs write");
    drive(1, 1, 3'd0, 32'h0000_0400, "R10 quiet ext write");
    drive(1, 1, 3'd5, 32'h0000_0000, "R11 quiet refresh no effect");
    drive(1, 0, 3'd6, 32'hFFFF_FFFF, "R11 selector 6 no effect");
    drive(1, 0, 3'd7, 32'hFFFF_FFFF, "R11 selector 7 no effect");
    drive(1, 0, 3'd5, 32'h0000_0000, "R11 refresh to 64-bit");
    for (int i = 0; i < 32; i++) begin
      logic [4:0] b;
      b = 5'(i);
      drive(1, 0, 3'd0, {21'd0, b[0], 10'd0}, "R3 R4 sweep ext");
      drive(1, 0, 3'd1, {b[2], 30'd0, b[1]}, "R4 R5 sweep cr0");
      drive(1, 0, 3'd4, {14'd0, b[3], 17'd0}, "R4 sweep flags");
      drive(1, 0, 3'd2, {28'd0, b[4], b[1] ^ b[3], b[1:0]}, "R3 R5 R6 R7 sweep cs");
      drive(1, 0, 3'd3, {29'd0, b[2] ^ b[4], 2'd0}, "R8 sweep ss");
    end
    idle("R9 final hold");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule